// File: doc/BRIEF.md
# Receive Page Ring Buffer Manager

This block stores incoming network frames into a circular receive area of local byte-wide memory. The memory is treated as pages of 256 bytes. The ring covers every page from a first page up to, but not including, a limit page. A MAC delivers each frame as a byte stream, marked by a start strobe, byte-valid strobes and an end strobe that carries an error flag. The block writes the payload into the ring. When the frame ends it writes a 4-byte header in front of the payload. It then moves its current-page pointer past the frame, so the host can find the next one.

The host owns a hold page, the oldest page it has not yet drained. The block never writes into the hold page. A frame that would reach it is abandoned and reported as an overrun. The block also reports a missed frame when it refuses a frame for lack of room or because listen-only mode is on. Erroneous frames are dropped unless the host asks for them to be kept. The host can load the current-page pointer while the block is idle. CRC checking, the MAC and the host bus lie outside this block.

Top module: `rxring_mgr`

## Requirements
- R1: While reset is held, and afterwards until the first frame or pointer load, `cur_pg` is 0, `mem_we` is 0 and `overrun`, `missed` and `stored` are 0.
- R2: Payload byte i of an accepted frame is written to page `cur_pg`, offset 4+i, with later bytes at consecutive addresses. The address is {page, offset}, with the page in the upper 8 bits.
- R3: After offset 255 of page `ring_stop_pg`-1, the next byte goes to offset 0 of `ring_start_pg`. Every memory write stays inside the ring.
- R4: After the end strobe of a kept frame, the 4 header bytes are written to offsets 0 to 3 of the frame's first page. Offset 0 holds the status: 0x01 for a clean frame, 0x02 for an erroneous frame that was kept. Offset 1 holds the next-page pointer. Offsets 2 and 3 hold the total count, which is the payload length plus 4, low byte first.
- R5: After the fourth header write, `stored` pulses for one cycle. At the same time `cur_pg` becomes the page after the page of the last byte written, wrapping at the limit page. That is the value written at header offset 1. At no other time does `cur_pg` change, except on a pointer load.
- R6: If `cur_pg` equals `host_hold_pg` at frame start, or a payload byte would land in the hold page, the block drops the frame. `overrun` and `missed` pulse together for one cycle, the block writes nothing into the hold page and writes no header, and `cur_pg` is unchanged.
- R7: When `mon_en` is 1, the block writes nothing for a frame, pulses `missed`, and leaves `cur_pg` unchanged.
- R8: A frame that ends with `rx_err`=1 while `keep_bad`=0 gets no header and no `stored` pulse, and `cur_pg` is unchanged. With `keep_bad`=1 the frame is stored with status 0x02.
- R9: The block writes header offsets 0 to 3 of the frame's first page only after the end strobe, exactly four times per stored frame and never for a dropped frame.
- R10: `cur_wr` in the idle state loads `cur_pg` with `cur_wr_pg`. The new value is visible after the sampling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_start_pg | input | 8 | First page of the ring |
| ring_stop_pg | input | 8 | Page just past the ring |
| host_hold_pg | input | 8 | Page the host still owns; never written |
| mon_en | input | 1 | Listen-only: frames are refused |
| keep_bad | input | 1 | Keep frames that end with an error |
| cur_wr | input | 1 | Load the current-page pointer |
| cur_wr_pg | input | 8 | Value for the pointer load |
| rx_sof | input | 1 | Frame start strobe |
| rx_valid | input | 1 | Payload byte strobe |
| rx_data | input | 8 | Payload byte |
| rx_eof | input | 1 | Frame end strobe |
| rx_err | input | 1 | Frame error, qualified by rx_eof |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | 16 | Memory byte address {page, offset} |
| mem_wdata | output | 8 | Memory write data |
| cur_pg | output | 8 | Current page pointer |
| overrun | output | 1 | One-cycle pulse: frame reached the hold page |
| missed | output | 1 | One-cycle pulse: frame not stored |
| stored | output | 1 | One-cycle pulse: frame and header stored |

## Verification
The assertions assume that the ring configuration, the hold page, `mon_en` and `keep_bad` change only while no frame is in flight. They also assume that the hold page and the current page lie inside the ring. Strobes must follow the order start, bytes, end, with at most one strobe per cycle. No new frame or pointer load may arrive during the four header cycles. The stimulus draws random hold pages from inside the ring, random lengths, error flags and modes. It changes configuration only before a start strobe and leaves eight idle cycles after every end strobe. Directed frames cover the wrap from the last ring page, frames ending exactly on a page edge, zero-length frames, and a hold page equal to the current page.

// File: rtl/rxring_pkg.sv
package rxring_pkg;

    localparam int CNT_W   = 16;
    localparam int HDR_LEN = 4;

    localparam logic [7:0] STAT_OK  = 8'h01;
    localparam logic [7:0] STAT_BAD = 8'h02;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DATA,
        ST_DROP,
        ST_HDR
    } rx_state_e;

endpackage

// File: rtl/rxring_page_inc.sv
module rxring_page_inc #(
    parameter int PAGE_W = 8
) (
    input  logic [PAGE_W-1:0] pg_i,
    input  logic [PAGE_W-1:0] ring_start_i,
    input  logic [PAGE_W-1:0] ring_stop_i,
    output logic [PAGE_W-1:0] pg_o
);

    logic [PAGE_W-1:0] plus1;

    assign plus1 = pg_i + 1'b1;
    assign pg_o  = (plus1 == ring_stop_i) ? ring_start_i : plus1;

endmodule

// File: rtl/rxring_hdr_mux.sv
module rxring_hdr_mux #(
    parameter int PAGE_W = 8
) (
    input  logic [1:0]                   idx_i,
    input  logic [7:0]                   stat_i,
    input  logic [PAGE_W-1:0]            nxt_i,
    input  logic [rxring_pkg::CNT_W-1:0] tot_i,
    output logic [7:0]                   byte_o
);

    always_comb begin
        unique case (idx_i)
            2'd0:    byte_o = stat_i;
            2'd1:    byte_o = 8'(nxt_i);
            2'd2:    byte_o = tot_i[7:0];
            default: byte_o = tot_i[15:8];
        endcase
    end

endmodule

// File: rtl/rxring_mgr.sv
module rxring_mgr
    import rxring_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PAGE_W-1:0]         ring_start_pg,
    input  logic [PAGE_W-1:0]         ring_stop_pg,
    input  logic [PAGE_W-1:0]         host_hold_pg,
    input  logic                      mon_en,
    input  logic                      keep_bad,
    input  logic                      cur_wr,
    input  logic [PAGE_W-1:0]         cur_wr_pg,
    input  logic                      rx_sof,
    input  logic                      rx_valid,
    input  logic [7:0]                rx_data,
    input  logic                      rx_eof,
    input  logic                      rx_err,
    output logic                      mem_we,
    output logic [PAGE_W+OFF_W-1:0]   mem_addr,
    output logic [7:0]                mem_wdata,
    output logic [PAGE_W-1:0]         cur_pg,
    output logic                      overrun,
    output logic                      missed,
    output logic                      stored
);

    localparam int AW = PAGE_W + OFF_W;
    localparam logic [OFF_W-1:0] DATA_OFF = OFF_W'(HDR_LEN);
    localparam logic [OFF_W-1:0] OFF_LAST = {OFF_W{1'b1}};

    typedef struct packed {
        rx_state_e         st;
        logic [PAGE_W-1:0] curr;
        logic [PAGE_W-1:0] wr_page;
        logic [OFF_W-1:0]  wr_off;
        logic [PAGE_W-1:0] last_page;
        logic [CNT_W-1:0]  cnt;
        logic              err;
        logic [1:0]        hidx;
        logic              we;
        logic [AW-1:0]     addr;
        logic [7:0]        wdata;
        logic              ovw;
        logic              miss;
        logic              done;
    } ring_regs_t;

    ring_regs_t q, d;

    logic [PAGE_W-1:0] wr_page_inc;
    logic [PAGE_W-1:0] next_frame_pg;
    logic [7:0]        hdr_byte;
    logic [7:0]        hdr_stat;
    logic [CNT_W-1:0]  hdr_total;
    logic              hdr_busy;

    rxring_page_inc #(.PAGE_W(PAGE_W)) u_inc_wr (
        .pg_i         (q.wr_page),
        .ring_start_i (ring_start_pg),
        .ring_stop_i  (ring_stop_pg),
        .pg_o         (wr_page_inc)
    );

    rxring_page_inc #(.PAGE_W(PAGE_W)) u_inc_last (
        .pg_i         (q.last_page),
        .ring_start_i (ring_start_pg),
        .ring_stop_i  (ring_stop_pg),
        .pg_o         (next_frame_pg)
    );

    assign hdr_stat  = q.err ? STAT_BAD : STAT_OK;
    assign hdr_total = q.cnt + CNT_W'(HDR_LEN);

    rxring_hdr_mux #(.PAGE_W(PAGE_W)) u_hdr (
        .idx_i  (q.hidx),
        .stat_i (hdr_stat),
        .nxt_i  (next_frame_pg),
        .tot_i  (hdr_total),
        .byte_o (hdr_byte)
    );

    assign hdr_busy = (q.st == ST_HDR);

    always_comb begin
        d      = q;
        d.we   = 1'b0;
        d.ovw  = 1'b0;
        d.miss = 1'b0;
        d.done = 1'b0;
        unique case (q.st)
            ST_IDLE: begin
                if (cur_wr) begin
                    d.curr = cur_wr_pg;
                end
                if (rx_sof) begin
                    if (mon_en) begin
                        d.miss = 1'b1;
                        d.st   = ST_DROP;
                    end else if (q.curr == host_hold_pg) begin
                        d.ovw  = 1'b1;
                        d.miss = 1'b1;
                        d.st   = ST_DROP;
                    end else begin
                        d.wr_page   = q.curr;
                        d.wr_off    = DATA_OFF;
                        d.last_page = q.curr;
                        d.cnt       = '0;
                        d.err       = 1'b0;
                        d.st        = ST_DATA;
                    end
                end
            end
            ST_DATA: begin
                if (rx_eof) begin
                    if (rx_err && !keep_bad) begin
                        d.st = ST_IDLE;
                    end else begin
                        d.err  = rx_err;
                        d.hidx = 2'd0;
                        d.st   = ST_HDR;
                    end
                end else if (rx_valid) begin
                    if (q.wr_page == host_hold_pg) begin
                        d.ovw  = 1'b1;
                        d.miss = 1'b1;
                        d.st   = ST_DROP;
                    end else begin
                        d.we        = 1'b1;
                        d.addr      = {q.wr_page, q.wr_off};
                        d.wdata     = rx_data;
                        d.last_page = q.wr_page;
                        d.cnt       = q.cnt + 1'b1;
                        d.wr_off    = q.wr_off + 1'b1;
                        if (q.wr_off == OFF_LAST) begin
                            d.wr_page = wr_page_inc;
                        end
                    end
                end
            end
            ST_DROP: begin
                if (rx_eof) begin
                    d.st = ST_IDLE;
                end
            end
            default: begin
                d.we    = 1'b1;
                d.addr  = {q.curr, {(OFF_W-2){1'b0}}, q.hidx};
                d.wdata = hdr_byte;
                d.hidx  = q.hidx + 1'b1;
                if (q.hidx == 2'd3) begin
                    d.curr = next_frame_pg;
                    d.done = 1'b1;
                    d.st   = ST_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st        <= ST_IDLE;
            q.curr      <= '0;
            q.wr_page   <= '0;
            q.wr_off    <= '0;
            q.last_page <= '0;
            q.cnt       <= '0;
            q.err       <= 1'b0;
            q.hidx      <= '0;
            q.we        <= 1'b0;
            q.addr      <= '0;
            q.wdata     <= '0;
            q.ovw       <= 1'b0;
            q.miss      <= 1'b0;
            q.done      <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign mem_we    = q.we;
    assign mem_addr  = q.addr;
    assign mem_wdata = q.wdata;
    assign cur_pg    = q.curr;
    assign overrun   = q.ovw;
    assign missed    = q.miss;
    assign stored    = q.done;

endmodule

// File: rtl/rxring_mgr_chk.sv
module rxring_mgr_chk #(
    parameter int PAGE_W = 8,
    parameter int OFF_W  = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [PAGE_W-1:0]       ring_start_pg,
    input logic [PAGE_W-1:0]       ring_stop_pg,
    input logic [PAGE_W-1:0]       host_hold_pg,
    input logic                    mon_en,
    input logic                    cur_wr,
    input logic                    mem_we,
    input logic [PAGE_W+OFF_W-1:0] mem_addr,
    input logic [PAGE_W-1:0]       cur_pg,
    input logic                    overrun,
    input logic                    missed,
    input logic                    stored,
    input logic                    hdr_busy
);

    logic [PAGE_W-1:0] w_pg;
    logic [OFF_W-1:0]  w_off;

    assign w_pg  = mem_addr[PAGE_W+OFF_W-1:OFF_W];
    assign w_off = mem_addr[OFF_W-1:0];

    p_no_hold_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (w_pg != host_hold_pg));

    p_in_ring_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (w_pg >= ring_start_pg && w_pg < ring_stop_pg));

    p_monitor_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mon_en |-> !mem_we);

    p_ovw_is_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> missed);

    p_hdr_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !hdr_busy) |-> !(w_pg == cur_pg && w_off < OFF_W'(4)));

    p_curr_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!stored && !$past(cur_wr)) |-> $stable(cur_pg));

    p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stored |=> !stored);

    p_done_in_ring_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stored |-> (cur_pg >= ring_start_pg && cur_pg < ring_stop_pg));

endmodule

bind rxring_mgr rxring_mgr_chk #(.PAGE_W(PAGE_W), .OFF_W(OFF_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .ring_start_pg (ring_start_pg),
    .ring_stop_pg  (ring_stop_pg),
    .host_hold_pg  (host_hold_pg),
    .mon_en        (mon_en),
    .cur_wr        (cur_wr),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .cur_pg        (cur_pg),
    .overrun       (overrun),
    .missed        (missed),
    .stored        (stored),
    .hdr_busy      (hdr_busy)
);

// File: tb/rxring_mgr_bench.sv
`timescale 1ns/1ps
module rxring_mgr_bench;

    localparam int PW = 8;
    localparam int OW = 8;
    localparam int AW = PW + OW;
    localparam logic [7:0] RSTART = 8'h40;
    localparam logic [7:0] RSTOP  = 8'h48;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [PW-1:0] ring_start_pg = RSTART;
    logic [PW-1:0] ring_stop_pg = RSTOP;
    logic [PW-1:0] host_hold_pg = RSTART;
    logic          mon_en = 1'b0;
    logic          keep_bad = 1'b0;
    logic          cur_wr = 1'b0;
    logic [PW-1:0] cur_wr_pg = '0;
    logic          rx_sof = 1'b0;
    logic          rx_valid = 1'b0;
    logic [7:0]    rx_data = '0;
    logic          rx_eof = 1'b0;
    logic          rx_err = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic [PW-1:0] cur_pg;
    logic          overrun;
    logic          missed;
    logic          stored;

    rxring_mgr #(.PAGE_W(PW), .OFF_W(OW)) u_rxring_mgr (
        .clk(clk), .rst_n(rst_n),
        .ring_start_pg(ring_start_pg), .ring_stop_pg(ring_stop_pg),
        .host_hold_pg(host_hold_pg), .mon_en(mon_en), .keep_bad(keep_bad),
        .cur_wr(cur_wr), .cur_wr_pg(cur_wr_pg),
        .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_eof(rx_eof), .rx_err(rx_err),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .cur_pg(cur_pg), .overrun(overrun), .missed(missed), .stored(stored)
    );

    always #2 clk = ~clk;

    int   n_tests = 0;
    int   n_fail  = 0;
    bit   finished = 1'b0;
    int   ev_ovw, ev_miss, ev_done, ev_wr, ev_wr_hold, ev_wr_hdr;
    logic [7:0] watch_pg = '0;
    logic [7:0] mem [int unsigned];

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                mem[int'(mem_addr)] = mem_wdata;
                ev_wr++;
                if (mem_addr[15:8] == host_hold_pg) ev_wr_hold++;
                if (mem_addr[15:8] == watch_pg && mem_addr[7:0] < 8'd4) ev_wr_hdr++;
            end
            if (overrun) ev_ovw++;
            if (missed)  ev_miss++;
            if (stored)  ev_done++;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pg_inc(input logic [7:0] pg);
        logic [7:0] p1 = pg + 8'd1;
        return (p1 == RSTOP) ? RSTART : p1;
    endfunction

    // kind: 0 stored, 1 overrun, 2 monitor refusal, 3 error drop
    task automatic model(input logic [7:0] curr, input logic [7:0] hold, input int len,
                         input bit err, input bit keep, input bit mon,
                         output int kind, output logic [7:0] nxt);
        logic [7:0] pg = curr;
        logic [7:0] last = curr;
        int off = 4;
        nxt = curr;
        if (mon) begin kind = 2; return; end
        if (curr == hold) begin kind = 1; return; end
        for (int i = 0; i < len; i++) begin
            if (pg == hold) begin kind = 1; return; end
            last = pg;
            off++;
            if (off == 256) begin off = 0; pg = pg_inc(pg); end
        end
        if (err && !keep) begin kind = 3; return; end
        kind = 0;
        nxt = pg_inc(last);
    endtask

    task automatic load_curr(input logic [7:0] v);
        @(negedge clk);
        cur_wr = 1'b1; cur_wr_pg = v;
        @(negedge clk);
        cur_wr = 1'b0;
        chk(cur_pg == v, "R10 pointer load", int'(cur_pg), int'(v));
    endtask

    task automatic run_frame(input logic [7:0] hold, input int len, input bit err,
                             input bit keep, input bit mon, input int seed);
        int kind;
        logic [7:0] nxt;
        logic [7:0] c0;
        int bad;
        logic [7:0] pg;
        int off;
        int tot;
        @(negedge clk);
        host_hold_pg = hold; keep_bad = keep; mon_en = mon;
        ev_ovw = 0; ev_miss = 0; ev_done = 0; ev_wr = 0; ev_wr_hold = 0; ev_wr_hdr = 0;
        c0 = cur_pg; watch_pg = cur_pg;
        model(c0, hold, len, err, keep, mon, kind, nxt);
        rx_sof = 1'b1;
        @(negedge clk);
        rx_sof = 1'b0;
        for (int i = 0; i < len; i++) begin
            if ($urandom % 6 == 0) @(negedge clk);
            rx_valid = 1'b1; rx_data = 8'(seed + i * 7);
            @(negedge clk);
            rx_valid = 1'b0;
        end
        rx_eof = 1'b1; rx_err = err;
        @(negedge clk);
        rx_eof = 1'b0; rx_err = 1'b0;
        repeat (8) @(negedge clk);
        case (kind)
            0: begin
                chk(ev_done == 1 && ev_ovw == 0 && ev_miss == 0, "R5 stored pulse", ev_done, 1);
                chk(cur_pg == nxt, "R5 next page", int'(cur_pg), int'(nxt));
                chk(mem[{c0, 8'd0}] == ((err && keep) ? 8'h02 : 8'h01), "R4 status byte",
                    int'(mem[{c0, 8'd0}]), (err && keep) ? 2 : 1);
                chk(mem[{c0, 8'd1}] == nxt, "R4 next pointer", int'(mem[{c0, 8'd1}]), int'(nxt));
                tot = len + 4;
                chk({mem[{c0, 8'd3}], mem[{c0, 8'd2}]} == 16'(tot), "R4 count",
                    int'({mem[{c0, 8'd3}], mem[{c0, 8'd2}]}), tot);
                chk(ev_wr_hdr == 4, "R9 header writes", ev_wr_hdr, 4);
                bad = 0; pg = c0; off = 4;
                for (int i = 0; i < len; i++) begin
                    if (mem[{pg, 8'(off)}] != 8'(seed + i * 7)) bad++;
                    off++;
                    if (off == 256) begin off = 0; pg = pg_inc(pg); end
                end
                chk(bad == 0, "R2 R3 payload placement", bad, 0);
                chk(ev_wr == len + 4, "R2 write count", ev_wr, len + 4);
            end
            1: begin
                chk(ev_ovw == 1 && ev_miss == 1, "R6 overrun and missed", ev_ovw * 16 + ev_miss, 17);
                chk(ev_wr_hold == 0 && ev_done == 0, "R6 hold page untouched", ev_wr_hold, 0);
                chk(cur_pg == c0, "R6 pointer kept", int'(cur_pg), int'(c0));
                chk(ev_wr_hdr == 0, "R9 no header", ev_wr_hdr, 0);
            end
            2: begin
                chk(ev_miss == 1 && ev_ovw == 0, "R7 missed pulse", ev_miss, 1);
                chk(ev_wr == 0, "R7 no writes", ev_wr, 0);
                chk(cur_pg == c0 && ev_done == 0, "R7 pointer kept", int'(cur_pg), int'(c0));
            end
            default: begin
                chk(ev_done == 0 && ev_ovw == 0 && ev_miss == 0, "R8 silent drop", ev_done, 0);
                chk(cur_pg == c0, "R8 pointer kept", int'(cur_pg), int'(c0));
                chk(ev_wr_hdr == 0, "R8 no header", ev_wr_hdr, 0);
            end
        endcase
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog (all R) actual=timeout expected=done");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        chk(cur_pg == 8'd0 && !mem_we && !overrun && !missed && !stored,
            "R1 reset state", int'(cur_pg), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(cur_pg == 8'd0 && !mem_we && !stored, "R1 after reset", int'(cur_pg), 0);

        load_curr(8'h40);
        run_frame(8'h45, 10, 1'b0, 1'b0, 1'b0, 3);
        run_frame(8'h45, 0, 1'b0, 1'b0, 1'b0, 5);
        run_frame(8'h45, 252, 1'b0, 1'b0, 1'b0, 9);
        run_frame(8'h40, 253, 1'b0, 1'b0, 1'b0, 11);
        load_curr(8'h47);
        run_frame(8'h44, 300, 1'b0, 1'b0, 1'b0, 13);
        chk(cur_pg == 8'h41, "R3 wrap to start page", int'(cur_pg), 8'h41);
        run_frame(8'h41, 20, 1'b0, 1'b0, 1'b0, 17);
        run_frame(8'h42, 300, 1'b0, 1'b0, 1'b0, 19);
        run_frame(8'h44, 30, 1'b0, 1'b0, 1'b1, 23);
        run_frame(8'h44, 30, 1'b1, 1'b0, 1'b0, 29);
        run_frame(8'h44, 30, 1'b1, 1'b1, 1'b0, 31);

        for (int f = 0; f < 120; f++) begin
            run_frame(8'(RSTART + ($urandom % 8)), int'($urandom % 520),
                      ($urandom % 4) == 0, ($urandom % 2) == 1,
                      ($urandom % 8) == 0, int'($urandom % 256));
        end

        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule